// File: doc/BRIEF.md
# Protected Segment Register Loader

This block loads a 16-bit selector into one of a small set of segment registers. It picks the global or local descriptor table from a bit of the selector and confirms that the 8-byte entry lies inside that table. It then fetches the entry as two 32-bit words through a memory port with one cycle of read latency. If the entry is present and the privilege rules allow it, the block fills the hidden part of the target register with the base, the effective limit and the attributes. If the entry's accessed bit was clear, the block sets it in memory.

Privilege is judged once, when the register is loaded. After that, a separate combinational check path takes a register number and an offset. It returns the linear address and whether the offset lies inside the cached limit. Both normal and expand-down limits are handled, and the current privilege level plays no part in this check. A load ends with a one-cycle `done` pulse that carries a fault code. A load that faults leaves the target register as it was.

Top module: `segLoader`

## Requirements
- R1: Selector bit 2 chooses the table (0 global, 1 local). Bits 15:3 are the entry index and bits 1:0 are the requested level. The entry address is the table base plus 8 times the index. The low word is read there and the high word at that address plus 4.
- R2: If index*8+7 exceeds the 16-bit limit of the chosen table, the load ends with fault code 1 and no memory read is issued.
- R3: If the high-word presence bit (bit 15) is 0, the load ends with fault code 2. This takes precedence over the privilege check.
- R4: With the descriptor level in high-word bits 14:13, the load ends with fault code 3 when max(current level, requested level) is greater than the descriptor level. A smaller number means more privilege.
- R5: Every load ends with `done` high for exactly one cycle, with `faultCode` valid in that cycle (0 means success). On any fault, the target register keeps its previous contents.
- R6: On success, the target register caches the selector and the base. The base is assembled as high-word bits 31:24, high-word bits 7:0 and low-word bits 31:16, from most to least significant.
- R7: The raw limit is high-word bits 19:16 joined above low-word bits 15:0. When the granularity bit (high-word bit 23) is 1, the effective limit is raw*4096+4095. Otherwise it is the raw value.
- R8: On success, if the accessed bit (high-word bit 8) was 0, the high word is written back with that bit set. If the bit was already 1, nothing is written.
- R9: For a normal segment, `chkOk` is 1 exactly when the register is valid and the offset is at most the effective limit. `chkLinear` is the cached base plus the offset.
- R10: A segment is expand-down when high-word bit 11 is 0 and bit 10 is 1. Its valid offsets are above the effective limit and at most an upper bound. The upper bound is 0xFFFF when high-word bit 22 is 0 and 0xFFFFFFFF when it is 1.
- R11: After reset no register is valid, `chkOk` is 0 and `done` is 0.
- R12: The check path ignores `curPriv`. Once a register is loaded, changing the current level does not change `chkOk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadReq | input | 1 | Start a load (taken when idle) |
| loadSel | input | 16 | Selector to load |
| loadSeg | input | SEG_W | Target segment register |
| curPriv | input | 2 | Current privilege level |
| gdtBase | input | 32 | Global table base address |
| gdtLimit | input | 16 | Global table byte limit |
| ldtBase | input | 32 | Local table base address |
| ldtLimit | input | 16 | Local table byte limit |
| memRdEn | output | 1 | Memory read strobe |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | 32 | Memory byte address |
| memWrData | output | 32 | Memory write data |
| memRdData | input | 32 | Read data, one cycle after memRdEn |
| done | output | 1 | Load finished (one-cycle pulse) |
| faultCode | output | 2 | 0 ok, 1 table limit, 2 not present, 3 privilege |
| chkSeg | input | SEG_W | Register examined by the check path |
| chkOffset | input | 32 | Offset to check |
| chkValid | output | 1 | Examined register holds a loaded descriptor |
| chkSel | output | 16 | Cached selector |
| chkBase | output | 32 | Cached base |
| chkLimit | output | 32 | Cached effective limit |
| chkLinear | output | 32 | Base plus offset |
| chkOk | output | 1 | Offset lies inside the segment |

## Verification
The hardest cases to reach from the ports are the ones where two faults are possible at once, and the rule that the accessed bit is written only on the first load of an entry. To reach them, the bench rewrites descriptors in its memory model between loads. It sweeps every descriptor level against every current and requested level, and it places absent entries where the privilege check would also fail. It counts memory writes around repeated loads of the same entry. It also probes table limits exactly at the last legal index and one past it.

// File: rtl/segLoaderPkg.sv
package segLoaderPkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_TABLE  = 2'd1,
    FLT_ABSENT = 2'd2,
    FLT_PRIV   = 2'd3
  } faultT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RDHI,
    ST_EVAL,
    ST_DECIDE
  } stateT;

  // strobes from control to datapath
  typedef struct packed {
    logic  latchReq;
    logic  rdLo;
    logic  rdHi;
    logic  capLo;
    logic  capHi;
    logic  commit;
    logic  wrBack;
    logic  finish;
    faultT code;
  } strobeT;

  // conditions reported by datapath
  typedef struct packed {
    logic idxOver;
    logic absent;
    logic privBad;
    logic accClear;
  } statusT;

endpackage

// File: rtl/segLoaderCtrl.sv
module segLoaderCtrl
  import segLoaderPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   loadReq,
  input  statusT sts,
  output strobeT stb
);

  stateT state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb       = '0;
    stb.code  = FLT_NONE;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (loadReq) begin
          stb.latchReq = 1'b1;
          stateNext    = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (sts.idxOver) begin
          stb.finish = 1'b1;
          stb.code   = FLT_TABLE;
          stateNext  = ST_IDLE;
        end else begin
          stb.rdLo  = 1'b1;
          stateNext = ST_RDHI;
        end
      end
      ST_RDHI: begin
        stb.capLo = 1'b1;
        stb.rdHi  = 1'b1;
        stateNext = ST_EVAL;
      end
      ST_EVAL: begin
        stb.capHi = 1'b1;
        stateNext = ST_DECIDE;
      end
      ST_DECIDE: begin
        stb.finish = 1'b1;
        stateNext  = ST_IDLE;
        if (sts.absent) begin
          stb.code = FLT_ABSENT;
        end else if (sts.privBad) begin
          stb.code = FLT_PRIV;
        end else begin
          stb.commit = 1'b1;
          stb.wrBack = sts.accClear;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/segLoaderPath.sv
module segLoaderPath
  import segLoaderPkg::*;
#(
  parameter int SEG_COUNT = 4,
  parameter int SEG_W     = 2
)(
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  output statusT           sts,
  input  logic [15:0]      loadSel,
  input  logic [SEG_W-1:0] loadSeg,
  input  logic [1:0]       curPriv,
  input  logic [31:0]      gdtBase,
  input  logic [15:0]      gdtLimit,
  input  logic [31:0]      ldtBase,
  input  logic [15:0]      ldtLimit,
  output logic             memRdEn,
  output logic             memWrEn,
  output logic [31:0]      memAddr,
  output logic [31:0]      memWrData,
  input  logic [31:0]      memRdData,
  output logic             done,
  output logic [1:0]       faultCode,
  input  logic [SEG_W-1:0] chkSeg,
  input  logic [31:0]      chkOffset,
  output logic             chkValid,
  output logic [15:0]      chkSel,
  output logic [31:0]      chkBase,
  output logic [31:0]      chkLimit,
  output logic [31:0]      chkLinear,
  output logic             chkOk
);

  localparam logic [31:0] SMALL_TOP = 32'h0000_FFFF;
  localparam logic [31:0] BIG_TOP   = 32'hFFFF_FFFF;
  localparam int          ACC_BIT   = 8;

  // request latched at start
  logic [15:0]      reqSel;
  logic [SEG_W-1:0] reqSeg;
  logic [1:0]       reqCpl;
  logic [31:0]      loWord, hiWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqSel <= '0;
      reqSeg <= '0;
      reqCpl <= '0;
      loWord <= '0;
      hiWord <= '0;
    end else begin
      if (stb.latchReq) begin
        reqSel <= loadSel;
        reqSeg <= loadSeg;
        reqCpl <= curPriv;
      end
      if (stb.capLo) loWord <= memRdData;
      if (stb.capHi) hiWord <= memRdData;
    end
  end

  // table selection and address
  logic        useLocal;
  logic [31:0] tblBase;
  logic [15:0] tblLimit;
  logic [15:0] lastByte;
  logic [31:0] descAddr;

  assign useLocal = reqSel[2];
  assign tblBase  = useLocal ? ldtBase : gdtBase;
  assign tblLimit = useLocal ? ldtLimit : gdtLimit;
  assign lastByte = {reqSel[15:3], 3'b111};
  assign descAddr = tblBase + {16'd0, reqSel[15:3], 3'b000};

  // descriptor decode
  logic [1:0]  descDpl;
  logic [1:0]  effPriv;
  logic [19:0] rawLimit;
  logic [31:0] effLimit;
  logic [31:0] descBase;
  logic        descExpDown;
  logic        descBig;

  assign descDpl     = hiWord[14:13];
  assign effPriv     = (reqCpl > reqSel[1:0]) ? reqCpl : reqSel[1:0];
  assign rawLimit    = {hiWord[19:16], loWord[15:0]};
  assign effLimit    = hiWord[23] ? {rawLimit, 12'hFFF} : {12'd0, rawLimit};
  assign descBase    = {hiWord[31:24], hiWord[7:0], loWord[31:16]};
  assign descExpDown = !hiWord[11] && hiWord[10];
  assign descBig     = hiWord[22];

  assign sts.idxOver  = lastByte > tblLimit;
  assign sts.absent   = !hiWord[15];
  assign sts.privBad  = effPriv > descDpl;
  assign sts.accClear = !hiWord[ACC_BIT];

  // memory port
  assign memRdEn   = stb.rdLo | stb.rdHi;
  assign memWrEn   = stb.wrBack;
  assign memAddr   = (stb.rdHi | stb.wrBack) ? (descAddr + 32'd4) : descAddr;
  assign memWrData = hiWord | (32'd1 << ACC_BIT);

  // completion
  always_ff @(posedge clk) begin
    if (!rstN) begin
      done      <= 1'b0;
      faultCode <= 2'd0;
    end else begin
      done      <= stb.finish;
      faultCode <= stb.finish ? stb.code : 2'd0;
    end
  end

  // segment register file (visible selector + hidden part)
  logic [SEG_COUNT-1:0] segValid;
  logic [SEG_COUNT-1:0] segExp;
  logic [SEG_COUNT-1:0] segBig;
  logic [15:0]          segSel   [SEG_COUNT];
  logic [31:0]          segBase  [SEG_COUNT];
  logic [31:0]          segLimit [SEG_COUNT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segValid <= '0;
      segExp   <= '0;
      segBig   <= '0;
      for (int s = 0; s < SEG_COUNT; s++) begin
        segSel[s]   <= '0;
        segBase[s]  <= '0;
        segLimit[s] <= '0;
      end
    end else if (stb.commit) begin
      for (int s = 0; s < SEG_COUNT; s++) begin
        if (reqSeg == SEG_W'(s)) begin
          segValid[s] <= 1'b1;
          segExp[s]   <= descExpDown;
          segBig[s]   <= descBig;
          segSel[s]   <= reqSel;
          segBase[s]  <= descBase;
          segLimit[s] <= effLimit;
        end
      end
    end
  end

  // access check path: limit only, privilege already settled
  logic [31:0] upperBound;
  logic        inRange;

  assign chkValid   = segValid[chkSeg];
  assign chkSel     = segSel[chkSeg];
  assign chkBase    = segBase[chkSeg];
  assign chkLimit   = segLimit[chkSeg];
  assign chkLinear  = segBase[chkSeg] + chkOffset;
  assign upperBound = segBig[chkSeg] ? BIG_TOP : SMALL_TOP;
  assign inRange    = segExp[chkSeg]
                    ? ((chkOffset > segLimit[chkSeg]) && (chkOffset <= upperBound))
                    : (chkOffset <= segLimit[chkSeg]);
  assign chkOk      = chkValid && inRange;

endmodule

// File: rtl/segLoader.sv
module segLoader
  import segLoaderPkg::*;
#(
  parameter int SEG_COUNT = 4,
  localparam int SEG_W    = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadReq,
  input  logic [15:0]      loadSel,
  input  logic [SEG_W-1:0] loadSeg,
  input  logic [1:0]       curPriv,
  input  logic [31:0]      gdtBase,
  input  logic [15:0]      gdtLimit,
  input  logic [31:0]      ldtBase,
  input  logic [15:0]      ldtLimit,
  output logic             memRdEn,
  output logic             memWrEn,
  output logic [31:0]      memAddr,
  output logic [31:0]      memWrData,
  input  logic [31:0]      memRdData,
  output logic             done,
  output logic [1:0]       faultCode,
  input  logic [SEG_W-1:0] chkSeg,
  input  logic [31:0]      chkOffset,
  output logic             chkValid,
  output logic [15:0]      chkSel,
  output logic [31:0]      chkBase,
  output logic [31:0]      chkLimit,
  output logic [31:0]      chkLinear,
  output logic             chkOk
);

  strobeT stb;
  statusT sts;

  segLoaderCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .loadReq (loadReq),
    .sts     (sts),
    .stb     (stb)
  );

  segLoaderPath #(.SEG_COUNT(SEG_COUNT), .SEG_W(SEG_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .sts       (sts),
    .loadSel   (loadSel),
    .loadSeg   (loadSeg),
    .curPriv   (curPriv),
    .gdtBase   (gdtBase),
    .gdtLimit  (gdtLimit),
    .ldtBase   (ldtBase),
    .ldtLimit  (ldtLimit),
    .memRdEn   (memRdEn),
    .memWrEn   (memWrEn),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .memRdData (memRdData),
    .done      (done),
    .faultCode (faultCode),
    .chkSeg    (chkSeg),
    .chkOffset (chkOffset),
    .chkValid  (chkValid),
    .chkSel    (chkSel),
    .chkBase   (chkBase),
    .chkLimit  (chkLimit),
    .chkLinear (chkLinear),
    .chkOk     (chkOk)
  );

endmodule

// File: rtl/segLoaderChk.sv
module segLoaderChk (
  input logic        clk,
  input logic        rstN,
  input logic        memRdEn,
  input logic        memWrEn,
  input logic [31:0] memWrData,
  input logic        done,
  input logic [1:0]  faultCode,
  input logic        chkValid,
  input logic        chkOk
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);                                   // R5
  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (faultCode != 2'd0) |-> done);                     // R5
  AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));                            // R1
  AST_WB_SETS_ACCESSED: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> memWrData[8]);                         // R8
  AST_WB_THEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> (done && faultCode == 2'd0));          // R8
  AST_OK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    chkOk |-> chkValid);                               // R9

endmodule

bind segLoader segLoaderChk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .memRdEn   (memRdEn),
  .memWrEn   (memWrEn),
  .memWrData (memWrData),
  .done      (done),
  .faultCode (faultCode),
  .chkValid  (chkValid),
  .chkOk     (chkOk)
);

// File: tb/segLoader_test.sv
module segLoader_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] GDT_BASE = 32'h40;
  localparam logic [15:0] GDT_LIM  = 16'h3F;
  localparam logic [31:0] LDT_BASE = 32'h80;
  localparam logic [15:0] LDT_LIM  = 16'h1F;

  logic        clk = 0;
  logic        rstN = 0;
  logic        loadReq = 0;
  logic [15:0] loadSel = 0;
  logic [1:0]  loadSeg = 0;
  logic [1:0]  curPriv = 0;
  logic        memRdEn, memWrEn;
  logic [31:0] memAddr, memWrData;
  logic [31:0] memRdData = 0;
  logic        done;
  logic [1:0]  faultCode;
  logic [1:0]  chkSeg = 0;
  logic [31:0] chkOffset = 0;
  logic        chkValid, chkOk;
  logic [15:0] chkSel;
  logic [31:0] chkBase, chkLimit, chkLinear;

  int checks = 0;
  int errors = 0;
  int rdCount = 0;
  int wrCount = 0;

  logic [31:0] mem [64];
  logic        hostWe = 0;
  logic [5:0]  hostAddr = 0;
  logic [31:0] hostData = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segLoader uut (
    .clk(clk), .rstN(rstN), .loadReq(loadReq), .loadSel(loadSel),
    .loadSeg(loadSeg), .curPriv(curPriv),
    .gdtBase(GDT_BASE), .gdtLimit(GDT_LIM), .ldtBase(LDT_BASE), .ldtLimit(LDT_LIM),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData),
    .done(done), .faultCode(faultCode),
    .chkSeg(chkSeg), .chkOffset(chkOffset), .chkValid(chkValid),
    .chkSel(chkSel), .chkBase(chkBase), .chkLimit(chkLimit),
    .chkLinear(chkLinear), .chkOk(chkOk)
  );

  // memory model, one cycle read latency
  always @(posedge clk) begin
    if (hostWe) mem[hostAddr] <= hostData;
    else if (memWrEn) begin
      mem[memAddr[7:2]] <= memWrData;
      wrCount <= wrCount + 1;
    end
    if (memRdEn) begin
      memRdData <= mem[memAddr[7:2]];
      rdCount <= rdCount + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic putWord(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWe = 1; hostAddr = a; hostData = d;
    @(negedge clk);
    hostWe = 0;
  endtask

  // type: 4'b0010 data, 4'b0110 expand-down data, 4'b1010 code
  task automatic putDesc(input logic isLocal, input int idx, input logic [31:0] base,
                         input logic [19:0] lim, input logic g, input logic d,
                         input logic p, input logic [1:0] dpl, input logic [3:0] typ);
    logic [31:0] lo, hi;
    logic [7:0]  w;
    lo = {base[15:0], lim[15:0]};
    hi = {base[31:24], g, d, 2'b00, lim[19:16], p, dpl, 1'b1, typ, base[23:16]};
    w  = (isLocal ? LDT_BASE[7:0] : GDT_BASE[7:0]) + 8'(idx * 8);
    putWord(w[7:2], lo);
    putWord(w[7:2] + 6'd1, hi);
  endtask

  task automatic doLoad(input logic [15:0] sel, input logic [1:0] seg,
                        input logic [1:0] cpl, output logic [1:0] code);
    @(negedge clk);
    loadSel = sel; loadSeg = seg; curPriv = cpl; loadReq = 1;
    @(negedge clk);
    loadReq = 0;
    while (!done) @(negedge clk);
    code = faultCode;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0]  fc;
    int          rd0, wr0;
    logic [15:0] prevSel;
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R11 reset state
    check("R11 done", {31'd0, done}, 0);
    for (int s = 0; s < 4; s++) begin
      chkSeg = 2'(s); chkOffset = 0; #1;
      check("R11 valid", {31'd0, chkValid}, 0);
      check("R11 ok", {31'd0, chkOk}, 0);
    end

    // R1 R6 global load, two reads
    putDesc(0, 1, 32'h1234_5678, 20'h00FFF, 0, 0, 1, 2'd3, 4'b0010);
    rd0 = rdCount; wr0 = wrCount;
    doLoad(16'h000B, 2'd0, 2'd3, fc);
    check("R6 fault", {30'd0, fc}, 0);
    check("R1 reads", rdCount - rd0, 2);
    chkSeg = 0; #1;
    check("R6 sel", {16'd0, chkSel}, 32'h000B);
    check("R6 base", chkBase, 32'h1234_5678);
    check("R7 bytes", chkLimit, 32'h0000_0FFF);
    // R8 write-back of accessed bit
    check("R8 wr count", wrCount - wr0, 1);
    check("R8 bit set", {31'd0, mem[(GDT_BASE[7:0] + 8'd12) >> 2][8]}, 1);
    wr0 = wrCount;
    doLoad(16'h000B, 2'd0, 2'd3, fc);
    check("R8 no rewrite", wrCount - wr0, 0);

    // R1 R7 local table, 4K granularity
    putDesc(1, 2, 32'h00AB_C000, 20'h12345, 1, 0, 1, 2'd0, 4'b1010);
    doLoad(16'h0014, 2'd1, 2'd0, fc);
    check("R1 local fault", {30'd0, fc}, 0);
    chkSeg = 1; #1;
    check("R1 local base", chkBase, 32'h00AB_C000);
    check("R7 pages", chkLimit, 32'h1234_5FFF);

    // R9 normal limit, R12 level independence
    chkSeg = 0;
    chkOffset = 32'h0FFF; #1;
    check("R9 at limit", {31'd0, chkOk}, 1);
    check("R9 linear", chkLinear, 32'h1234_6677);
    chkOffset = 32'h1000; #1;
    check("R9 past limit", {31'd0, chkOk}, 0);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); curPriv = 2'(c);
      chkOffset = 32'h0FFF; #1;
      check("R12 level ignored", {31'd0, chkOk}, 1);
    end

    // R10 expand-down, small and big upper bound
    putDesc(0, 3, 32'h0, 20'h00100, 0, 0, 1, 2'd3, 4'b0110);
    doLoad(16'h0018, 2'd2, 2'd0, fc);
    check("R10 load", {30'd0, fc}, 0);
    chkSeg = 2;
    chkOffset = 32'h100;   #1; check("R10 at limit", {31'd0, chkOk}, 0);
    chkOffset = 32'h101;   #1; check("R10 above", {31'd0, chkOk}, 1);
    chkOffset = 32'hFFFF;  #1; check("R10 top small", {31'd0, chkOk}, 1);
    chkOffset = 32'h10000; #1; check("R10 over small", {31'd0, chkOk}, 0);
    putDesc(0, 4, 32'h0, 20'h00100, 0, 1, 1, 2'd3, 4'b0110);
    doLoad(16'h0020, 2'd2, 2'd0, fc);
    chkOffset = 32'h10000;     #1; check("R10 big mid", {31'd0, chkOk}, 1);
    chkOffset = 32'hFFFF_FFFF; #1; check("R10 big top", {31'd0, chkOk}, 1);
    chkOffset = 32'h100;       #1; check("R10 big at limit", {31'd0, chkOk}, 0);

    // R2 table limit boundaries
    putDesc(0, 7, 32'h7000, 20'h1, 0, 0, 1, 2'd3, 4'b0010);
    doLoad(16'h0038, 2'd3, 2'd0, fc);
    check("R2 last global", {30'd0, fc}, 0);
    rd0 = rdCount;
    doLoad(16'h0040, 2'd3, 2'd0, fc);
    check("R2 global over", {30'd0, fc}, 1);
    check("R2 no read", rdCount - rd0, 0);
    putDesc(1, 3, 32'h3000, 20'h1, 0, 0, 1, 2'd3, 4'b0010);
    doLoad(16'h001C, 2'd3, 2'd0, fc);
    check("R2 last local", {30'd0, fc}, 0);
    doLoad(16'h0024, 2'd3, 2'd0, fc);
    check("R2 local over", {30'd0, fc}, 1);
    chkSeg = 3; chkOffset = 0; #1;
    check("R5 kept after table fault", {16'd0, chkSel}, 32'h001C);

    // R3 absent beats privilege, R5 register kept
    putDesc(0, 5, 32'h5000, 20'h1, 0, 0, 0, 2'd0, 4'b0010);
    doLoad(16'h002B, 2'd0, 2'd3, fc);
    check("R3 absent", {30'd0, fc}, 2);
    chkSeg = 0; #1;
    check("R5 kept sel", {16'd0, chkSel}, 32'h000B);
    check("R5 kept base", chkBase, 32'h1234_5678);

    // R4 privilege sweep
    prevSel = 16'h001C;
    for (int d = 0; d < 4; d++) begin
      for (int c = 0; c < 4; c++) begin
        for (int r = 0; r < 4; r++) begin
          logic [15:0] sel;
          logic [1:0]  exp;
          putDesc(0, 6, 32'h6000 + 32'(d), 20'h10, 0, 0, 1, 2'(d), 4'b0010);
          sel = 16'h0030 | 16'(r);
          exp = (((c > r) ? c : r) > d) ? 2'd3 : 2'd0;
          doLoad(sel, 2'd3, 2'(c), fc);
          check("R4 privilege", {30'd0, fc}, {30'd0, exp});
          if (exp == 2'd0) prevSel = sel;
          chkSeg = 3; #1;
          check("R5 R4 selector", {16'd0, chkSel}, {16'd0, prevSel});
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule